// File: doc/BRIEF.md
# Flash Bus Mode Controller

This block is the control side of a 16-bit NOR-style flash device as a CPU bus sees it. The device is selected by three active-low selects: one device select and two byte-lane selects. Output enable, write enable, a reset/power-down pin and a write-protect pin complete the bus. Commands are written through the data bus. They select what a read returns: the storage array, identification words, a 48-entry query table or the status register. Two-cycle command sequences start a word program or a block erase. Each runs as a fixed-latency busy period, and a status pin reports it.

The data bus is split into an output word `dq_out` and one drive enable per byte lane (`dq_oe`). A lane whose enable is low is high-impedance. Holding the reset/power-down pin low for long enough puts the device into deep power-down. This aborts any busy operation and reinitialises the command state. On release, a wake-up window blanks the outputs and a recovery window blocks command writes. The storage array is a plain behavioural memory that is reset to all ones.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After `rst_n` the device is in array-read mode, every word reads FFFFh, the status register reads 80h and `sts` is high.
- R2: `dq_oe[0]` (bits 7:0) is high only when `sel_n`=0, `lane_lo_n`=0, `oe_n`=0, `we_n`=1, `rp_n`=1, the device is not powered down and no wake-up window runs. `dq_oe[1]` (bits 15:8) follows the same rule with `lane_hi_n`. Otherwise the lane is high-impedance, whatever `oe_n` does.
- R3: A command is taken from `dq_in[7:0]` at the clock edge that sees `we_n` rise while the device is selected (`sel_n`=0 and at least one lane select low). FFh selects array read, 90h identification, 98h query and 70h status. Any other single-cycle code leaves the mode unchanged.
- R4: In identification mode, address 0 returns `MFR_ID` and address 1 returns `DEV_ID`. An address whose offset within its block is 2 returns a block word whose bit 1 is set if an erase of that block was aborted. All other addresses return 0. A block is 2^BLK_W words.
- R5: In query mode, address i below 48 returns i on the low byte, except that 16, 17 and 18 return 51h, 52h and 59h. Addresses of 48 and above return 00h. The high lane stays high-impedance.
- R6: Status mode returns the status register on the low byte and 00h on the high byte. Bit 7 is 1 when ready and 0 while busy. `sts` is low whenever an operation is busy.
- R7: 40h followed by a data write programs that address with the AND of the old word and the data. The device is busy for `BUSY_CYC` cycles after the second write, the word changes when the busy period ends, and the mode becomes status.
- R8: 20h followed by D0h erases the block holding the address to FFFFh after `BUSY_CYC` cycles. Any other second code sets status bits 5 and 4 without starting an operation. Both cases leave the device in status mode.
- R9: With `wp_n` low at the second write, a program sets status bits 4 and 1, and an erase sets bits 5 and 1, with no busy period. 50h clears bits 5, 4 and 1.
- R10: Command writes during a busy period are ignored. Deselecting the device does not stop a busy operation.
- R11: `rp_n` low for fewer than `PD_MIN` consecutive edges only blanks outputs and blocks commands; a running operation continues. At the `PD_MIN`-th low edge the device powers down: any busy operation is aborted, status becomes 80h and the mode becomes array read.
- R12: After power-down ends, the outputs stay high-impedance for `WAKE_CYC` cycles and command writes are ignored for `REC_CYC` cycles. After an abort, `sts` stays low until the wake-up window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| sel_n | input | 1 | Device select, active low |
| lane_lo_n | input | 1 | Low byte-lane select, active low |
| lane_hi_n | input | 1 | High byte-lane select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, command taken on its rise |
| rp_n | input | 1 | Reset/power-down, active low |
| wp_n | input | 1 | Write protect, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data and command codes |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-lane drive enable (bit 0 low byte) |
| sts | output | 1 | Ready pin, low while busy or aborting |

## Verification
On every cycle, the assertions check the electrical rules: no lane is driven with output enable high, during reset/power-down or during the wake-up window. They also check that the high lane is silent in query mode, that `sts` is low whenever the busy counter runs, that the counter steps down by one, and that power-down entry leaves status and mode in their initial state. Only the bench's scenarios can show the data-side effects: the AND behaviour of programming, erase confinement to one block, rejected protected operations, commands lost during busy or recovery, a short reset pulse that leaves a program running, and the aborted-erase flag in the identification words.

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl #(
  parameter int ADDR_W = 8,
  parameter int BLK_W = 6,
  parameter int BUSY_CYC = 12,
  parameter int PD_MIN = 4,
  parameter int WAKE_CYC = 6,
  parameter int REC_CYC = 5,
  parameter logic [15:0] MFR_ID = 16'h00B0,
  parameter logic [15:0] DEV_ID = 16'h00A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              rp_n,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe,
  output logic              sts
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NBLK = 1 << (ADDR_W - BLK_W);
  localparam int CNT_W = $clog2(BUSY_CYC + WAKE_CYC + REC_CYC + PD_MIN + 1);
  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_QRY = 2'd2, M_SR = 2'd3;
  localparam logic [1:0] S_NONE = 2'd0, S_PROG = 2'd1, S_ERA = 2'd2;

  logic [15:0]       mem [DEPTH];
  logic [1:0]        mode, setup;
  logic [6:0]        sr_err;
  logic [CNT_W-1:0]  busy_cnt, pd_cnt, wake_cnt, rec_cnt;
  logic              pd_done, abort, we_q, op_erase;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_data;
  logic [NBLK-1:0]   era_bad;
  logic [15:0]       id_word;

  wire selected = !sel_n && (!lane_lo_n || !lane_hi_n);
  wire busy     = busy_cnt != '0;
  wire wr_evt   = !we_q && we_n && selected && rp_n && !pd_done && rec_cnt == '0 && !busy;
  wire rd_ok    = selected && !oe_n && we_n && rp_n && !pd_done && wake_cnt == '0;

  assign dq_oe[0] = rd_ok && !lane_lo_n;
  assign dq_oe[1] = rd_ok && !lane_hi_n && mode != M_QRY;
  assign sts = !(busy || abort);

  function automatic logic [7:0] qry(input logic [ADDR_W-1:0] a);
    if (int'(a) >= 48) return 8'h00;
    case (int'(a))
      16: return 8'h51;
      17: return 8'h52;
      18: return 8'h59;
      default: return 8'(a);
    endcase
  endfunction

  always_comb begin
    if (int'(addr) == 0) id_word = MFR_ID;
    else if (int'(addr) == 1) id_word = DEV_ID;
    else if (int'(addr[BLK_W-1:0]) == 2)
      id_word = {14'd0, era_bad[addr[ADDR_W-1:BLK_W]], 1'b0};
    else id_word = 16'h0000;
  end

  always_comb begin
    case (mode)
      M_ARR:   dq_out = mem[addr];
      M_ID:    dq_out = id_word;
      M_QRY:   dq_out = {8'h00, qry(addr)};
      default: dq_out = {8'h00, !busy, sr_err};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
      mode <= M_ARR;
      setup <= S_NONE;
      sr_err <= '0;
      busy_cnt <= '0;
      pd_cnt <= '0;
      wake_cnt <= '0;
      rec_cnt <= '0;
      pd_done <= 1'b0;
      abort <= 1'b0;
      we_q <= 1'b1;
      op_erase <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      era_bad <= '0;
    end else begin
      we_q <= we_n;

      if (wake_cnt != '0) begin
        wake_cnt <= wake_cnt - 1'b1;
        if (wake_cnt == CNT_W'(1)) abort <= 1'b0;
      end
      if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;

      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == CNT_W'(1)) begin
          if (op_erase) begin
            for (int i = 0; i < DEPTH; i++)
              if (ADDR_W'(i) >> BLK_W == op_addr >> BLK_W) mem[i] <= 16'hFFFF;
            era_bad[op_addr[ADDR_W-1:BLK_W]] <= 1'b0;
          end else begin
            mem[op_addr] <= mem[op_addr] & op_data;
          end
        end
      end

      if (!rp_n) begin
        if (!pd_done) begin
          if (pd_cnt == CNT_W'(PD_MIN - 1)) begin
            pd_done <= 1'b1;
            mode <= M_ARR;
            setup <= S_NONE;
            sr_err <= '0;
            busy_cnt <= '0;
            if (busy) begin
              abort <= 1'b1;
              if (op_erase) era_bad[op_addr[ADDR_W-1:BLK_W]] <= 1'b1;
            end
          end else begin
            pd_cnt <= pd_cnt + 1'b1;
          end
        end
      end else begin
        pd_cnt <= '0;
        if (pd_done) begin
          pd_done <= 1'b0;
          wake_cnt <= CNT_W'(WAKE_CYC);
          rec_cnt <= CNT_W'(REC_CYC);
        end
      end

      if (wr_evt) begin
        case (setup)
          S_PROG: begin
            setup <= S_NONE;
            mode <= M_SR;
            if (!wp_n) sr_err <= sr_err | 7'h12;
            else begin
              op_erase <= 1'b0;
              op_addr <= addr;
              op_data <= dq_in;
              busy_cnt <= CNT_W'(BUSY_CYC);
            end
          end
          S_ERA: begin
            setup <= S_NONE;
            mode <= M_SR;
            if (dq_in[7:0] != 8'hD0) sr_err <= sr_err | 7'h30;
            else if (!wp_n) sr_err <= sr_err | 7'h22;
            else begin
              op_erase <= 1'b1;
              op_addr <= addr;
              busy_cnt <= CNT_W'(BUSY_CYC);
            end
          end
          default: begin
            case (dq_in[7:0])
              8'hFF: mode <= M_ARR;
              8'h90: mode <= M_ID;
              8'h98: mode <= M_QRY;
              8'h70: mode <= M_SR;
              8'h50: sr_err <= sr_err & ~7'h32;
              8'h40: setup <= S_PROG;
              8'h20: setup <= S_ERA;
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_mode_ctrl_chk.sv
module flash_mode_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             rp_n,
  input logic [1:0]       dq_oe,
  input logic [1:0]       mode,
  input logic             sts,
  input logic             pd_done,
  input logic [CNT_W-1:0] busy_cnt,
  input logic [CNT_W-1:0] wake_cnt,
  input logic [6:0]       sr_err
);
  assert_hiz_oe_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dq_oe == 2'b00);

  assert_query_low_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> !dq_oe[1]);

  assert_sts_low_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt != '0 |-> !sts);

  assert_busy_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0 && rp_n) |=> busy_cnt == $past(busy_cnt) - CNT_W'(1));

  assert_pd_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_done) |-> (mode == 2'd0 && sr_err == 7'd0 && busy_cnt == '0));

  assert_rp_low_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |-> dq_oe == 2'b00);

  assert_wake_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cnt != '0 |-> dq_oe == 2'b00);
endmodule

bind flash_mode_ctrl flash_mode_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .oe_n(oe_n),
  .rp_n(rp_n),
  .dq_oe(dq_oe),
  .mode(mode),
  .sts(sts),
  .pd_done(pd_done),
  .busy_cnt(busy_cnt),
  .wake_cnt(wake_cnt),
  .sr_err(sr_err)
);

// File: tb/flash_mode_ctrl_bench.sv
`timescale 1ns/1ps
module flash_mode_ctrl_bench;
  localparam int AW = 8, BW = 6, BUSY = 12, PDM = 4, WAKE = 6, REC = 5;
  localparam logic [15:0] MFR = 16'h00B0, DEV = 16'h00A5;

  logic clk = 0, rst_n = 0, sel_n = 1, lane_lo_n = 1, lane_hi_n = 1;
  logic oe_n = 1, we_n = 1, rp_n = 1, wp_n = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0] dq_oe;
  logic sts;

  flash_mode_ctrl #(.ADDR_W(AW), .BLK_W(BW), .BUSY_CYC(BUSY), .PD_MIN(PDM),
    .WAKE_CYC(WAKE), .REC_CYC(REC), .MFR_ID(MFR), .DEV_ID(DEV)) u_flash_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n), .wp_n(wp_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .sts(sts));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model state
  int m_mode = 0, m_setup = 0, m_sr = 0, m_busy = 0, m_pd = 0, m_pdcnt = 0;
  int m_wake = 0, m_rec = 0, m_abort = 0, m_weq = 1, m_oper = 0, m_oaddr = 0, m_odata = 0;
  int mmem[256];
  int m_bad[4];
  int bpre, rise, msel, wr_ok, cmd;

  function automatic int qval(int a);
    if (a >= 48) return 0;
    if (a == 16) return 'h51;
    if (a == 17) return 'h52;
    if (a == 18) return 'h59;
    return a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mmem[i]) mmem[i] = 'hFFFF;
      foreach (m_bad[i]) m_bad[i] = 0;
      m_mode = 0; m_setup = 0; m_sr = 0; m_busy = 0; m_pd = 0; m_pdcnt = 0;
      m_wake = 0; m_rec = 0; m_abort = 0; m_weq = 1;
    end else begin
      bpre = (m_busy != 0);
      rise = (m_weq == 0 && we_n);
      m_weq = we_n;
      msel = (!sel_n && (!lane_lo_n || !lane_hi_n));
      wr_ok = rise && msel && rp_n && !m_pd && m_rec == 0 && !bpre;
      if (m_wake > 0) begin
        if (m_wake == 1) m_abort = 0;
        m_wake--;
      end
      if (m_rec > 0) m_rec--;
      if (bpre) begin
        m_busy--;
        if (m_busy == 0) begin
          if (m_oper) begin
            for (int i = 0; i < 64; i++) mmem[(m_oaddr / 64) * 64 + i] = 'hFFFF;
            m_bad[m_oaddr / 64] = 0;
          end else mmem[m_oaddr] = mmem[m_oaddr] & m_odata;
        end
      end
      if (!rp_n) begin
        if (!m_pd) begin
          if (m_pdcnt == PDM - 1) begin
            m_pd = 1; m_mode = 0; m_setup = 0; m_sr = 0; m_busy = 0;
            if (bpre) begin
              m_abort = 1;
              if (m_oper) m_bad[m_oaddr / 64] = 1;
            end
          end else m_pdcnt++;
        end
      end else begin
        m_pdcnt = 0;
        if (m_pd) begin
          m_pd = 0; m_wake = WAKE; m_rec = REC;
        end
      end
      if (wr_ok) begin
        cmd = int'(dq_in[7:0]);
        if (m_setup == 1) begin
          m_setup = 0; m_mode = 3;
          if (!wp_n) m_sr = m_sr | 'h12;
          else begin
            m_oper = 0; m_oaddr = int'(addr); m_odata = int'(dq_in); m_busy = BUSY;
          end
        end else if (m_setup == 2) begin
          m_setup = 0; m_mode = 3;
          if (cmd != 'hD0) m_sr = m_sr | 'h30;
          else if (!wp_n) m_sr = m_sr | 'h22;
          else begin
            m_oper = 1; m_oaddr = int'(addr); m_busy = BUSY;
          end
        end else begin
          case (cmd)
            'hFF: m_mode = 0;
            'h90: m_mode = 1;
            'h98: m_mode = 2;
            'h70: m_mode = 3;
            'h50: m_sr = m_sr & ~'h32;
            'h40: m_setup = 1;
            'h20: m_setup = 2;
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int rd, a, edq;
      logic [1:0] eoe;
      logic [15:0] mask;
      a = int'(addr);
      rd = (!sel_n && (!lane_lo_n || !lane_hi_n)) && !oe_n && we_n && rp_n && !m_pd && m_wake == 0;
      eoe = {1'(rd && !lane_hi_n && m_mode != 2), 1'(rd && !lane_lo_n)};
      case (m_mode)
        0: edq = mmem[a];
        1: edq = (a == 0) ? int'(MFR) : (a == 1) ? int'(DEV) : (a % 64 == 2) ? (m_bad[a / 64] << 1) : 0;
        2: edq = qval(a);
        default: edq = (m_busy == 0) ? ('h80 | m_sr) : m_sr;
      endcase
      mask = {{8{eoe[1]}}, {8{eoe[0]}}};
      chk("R2 lane enables vs model", {14'd0, dq_oe}, {14'd0, eoe});
      chk("R3 read data vs model", dq_out & mask, 16'(edq) & mask);
      chk("R6 sts vs model", {15'd0, sts}, {15'd0, 1'(!(m_busy != 0 || m_abort))});
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic wr(logic [15:0] d, logic [AW-1:0] a);
    step(); sel_n = 0; lane_lo_n = 0; lane_hi_n = 0; oe_n = 1; we_n = 0; addr = a; dq_in = d;
    step(); we_n = 1;
    step(); sel_n = 1; lane_lo_n = 1; lane_hi_n = 1;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [15:0] exp, logic [1:0] eoe, string tag);
    step(); sel_n = 0; lane_lo_n = 0; lane_hi_n = 0; oe_n = 0; addr = a;
    @(negedge clk);
    chk({tag, " lanes"}, {14'd0, dq_oe}, {14'd0, eoe});
    chk(tag, dq_out & {{8{eoe[1]}}, {8{eoe[0]}}}, exp);
    #1; oe_n = 1; sel_n = 1; lane_lo_n = 1; lane_hi_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1
    rd(0, 16'hFFFF, 2'b11, "R1 array after reset");
    chk("R1 sts high after reset", {15'd0, sts}, 16'd1);
    // R2
    step(); sel_n = 0; lane_lo_n = 0; lane_hi_n = 0; oe_n = 1;
    @(negedge clk); chk("R2 oe high hiz", {14'd0, dq_oe}, 16'd0);
    #1 oe_n = 0; sel_n = 1;
    @(negedge clk); chk("R2 standby hiz", {14'd0, dq_oe}, 16'd0);
    #1 sel_n = 0; lane_hi_n = 1;
    @(negedge clk); chk("R2 low lane only", {14'd0, dq_oe}, 16'd1);
    #1 we_n = 0;
    @(negedge clk); chk("R2 we low hiz", {14'd0, dq_oe}, 16'd0);
    #1 sel_n = 1; lane_lo_n = 1; we_n = 1; oe_n = 1;
    // R3 / R4
    wr(16'h0090, 0);
    rd(0, MFR, 2'b11, "R4 manufacturer word");
    rd(1, DEV, 2'b11, "R4 device word");
    rd(66, 16'h0000, 2'b11, "R4 block status clean");
    wr(16'h0033, 0);
    rd(1, DEV, 2'b11, "R3 unknown code keeps mode");
    // R5
    wr(16'h0098, 0);
    rd(16, 16'h0051, 2'b01, "R5 query 16");
    rd(18, 16'h0059, 2'b01, "R5 query 18");
    rd(5, 16'h0005, 2'b01, "R5 query 5");
    rd(50, 16'h0000, 2'b01, "R5 query beyond table");
    // R6
    wr(16'h0070, 0);
    rd(3, 16'h0080, 2'b11, "R6 status ready");
    // R7
    wr(16'h0040, 5); wr(16'h1234, 5);
    chk("R7 sts low when busy", {15'd0, sts}, 16'd0);
    rd(5, 16'h0000, 2'b11, "R6 status busy");
    idle(BUSY);
    rd(5, 16'h0080, 2'b11, "R7 status after program");
    wr(16'h00FF, 0);
    rd(5, 16'h1234, 2'b11, "R7 programmed word");
    wr(16'h0040, 5); wr(16'h0FF0, 5); idle(BUSY + 2); wr(16'h00FF, 0);
    rd(5, 16'h0230, 2'b11, "R7 program ANDs");
    // R10
    wr(16'h0040, 6); wr(16'h5A5A, 6);
    wr(16'h00FF, 0);
    chk("R10 busy continues deselected", {15'd0, sts}, 16'd0);
    idle(BUSY);
    rd(0, 16'h0080, 2'b11, "R10 write during busy ignored");
    wr(16'h00FF, 0);
    rd(6, 16'h5A5A, 2'b11, "R10 program completed");
    // R8
    wr(16'h0040, 70); wr(16'h0000, 70); idle(BUSY + 2); wr(16'h00FF, 0);
    rd(70, 16'h0000, 2'b11, "R8 block one programmed");
    wr(16'h0020, 64); wr(16'h00D0, 64); idle(BUSY + 2); wr(16'h00FF, 0);
    rd(70, 16'hFFFF, 2'b11, "R8 block erased");
    rd(5, 16'h0230, 2'b11, "R8 other block untouched");
    wr(16'h0020, 64); wr(16'h0033, 64);
    rd(0, 16'h00B0, 2'b11, "R8 bad erase sequence");
    // R9
    wr(16'h0050, 0);
    rd(0, 16'h0080, 2'b11, "R9 clear status");
    wp_n = 0;
    wr(16'h0040, 7); wr(16'h0000, 7);
    chk("R9 no busy when protected", {15'd0, sts}, 16'd1);
    rd(0, 16'h0092, 2'b11, "R9 protected program");
    wr(16'h0020, 0); wr(16'h00D0, 0);
    rd(0, 16'h00B2, 2'b11, "R9 protected erase");
    wp_n = 1;
    wr(16'h0050, 0); wr(16'h00FF, 0);
    rd(7, 16'hFFFF, 2'b11, "R9 protected word unchanged");
    // R11 short pulse
    wr(16'h0040, 8); wr(16'h0000, 8);
    step(); rp_n = 0; sel_n = 0; lane_lo_n = 0; lane_hi_n = 0; oe_n = 0;
    @(negedge clk); chk("R11 hiz while rp low", {14'd0, dq_oe}, 16'd0);
    #1;
    idle(PDM - 3);
    rp_n = 1; sel_n = 1; lane_lo_n = 1; lane_hi_n = 1; oe_n = 1;
    idle(BUSY); wr(16'h00FF, 0);
    rd(8, 16'h0000, 2'b11, "R11 short pulse keeps program");
    // R11 / R12 abort
    wr(16'h0020, 128); wr(16'h00D0, 128);
    step(); rp_n = 0;
    idle(PDM + 2);
    chk("R12 sts low after abort", {15'd0, sts}, 16'd0);
    rp_n = 1;
    step(); sel_n = 0; lane_lo_n = 0; lane_hi_n = 0; oe_n = 0;
    @(negedge clk);
    chk("R12 wake hiz", {14'd0, dq_oe}, 16'd0);
    chk("R12 sts low in wake", {15'd0, sts}, 16'd0);
    #1; sel_n = 1; lane_lo_n = 1; lane_hi_n = 1; oe_n = 1;
    wr(16'h0090, 0);
    idle(WAKE + REC);
    chk("R12 sts released", {15'd0, sts}, 16'd1);
    rd(0, 16'hFFFF, 2'b11, "R12 command in recovery ignored");
    wr(16'h0070, 0);
    rd(0, 16'h0080, 2'b11, "R11 status after power-down");
    wr(16'h0090, 0);
    rd(130, 16'h0002, 2'b11, "R4 aborted erase flag");
    rd(2, 16'h0000, 2'b11, "R4 other block flag clear");
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule